// File: doc/BRIEF.md
# Absolute-Address Load/Store Bus Sequencer

This block reproduces, cycle by cycle, the external bus behaviour of a small 8-bit processor core that executes a reduced instruction set. The supported instructions are load-accumulator-immediate, load-accumulator-absolute and store-accumulator-absolute. Every other opcode runs as a two-cycle no-operation. The block holds a program counter, an accumulator and a latched two-byte effective address. Each processor cycle drives a 16-bit address, a read strobe and an 8-bit write-data bus, and it samples an 8-bit read-data bus.

Each processor cycle is two clock periods long. The `phi2` input marks the halves: it is low for the first half (phi1) and high for the second half (phi2). The address and the strobe change only when a new cycle begins. Incoming data is taken only on the clock edge that ends phi2. Outgoing write data changes only at the start of phi2. The block is meant for bus-timing models and for testing memory and peripheral models against an exact access order.

Top module: `absbus_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the clock edge that releases it, the block shows `addrBus` = 0x0000, `rwRead` = 1 and `dataOut` = 0x00. The first cycle after reset fetches an opcode at address 0x0000.
- R2: Load absolute (opcode 0xAD) and store absolute (opcode 0x8D) each take four cycles. The addresses on the bus are PC, PC+1, PC+2 and then the effective address.
- R3: The effective address combines two fetched bytes. Its upper byte is the byte from the third cycle and its lower byte is the byte from the second cycle.
- R4: PC advances after each of the three fetches of an absolute instruction. The opcode fetch that follows is therefore at the old PC+3.
- R5: `rwRead` is 1 in every half-cycle, except in both halves of the fourth cycle of a store absolute, where it is 0.
- R6: Read data is taken only in phi2. Any value on `dataIn` during phi1 has no effect on the accumulator or on any latched address byte.
- R7: In the store cycle, `dataOut` still holds the byte it last drove during phi1, and holds the accumulator during phi2. At every other time it keeps its last value.
- R8: `addrBus` and `rwRead` keep the same value through phi1 and phi2 of one cycle.
- R9: Load immediate (opcode 0xA9) takes two cycles. It reads the opcode at PC and then the operand at PC+1, which goes into the accumulator. The next fetch is at PC+2.
- R10: Any other opcode takes two cycles. The second cycle reads at PC+1 without advancing PC again, so the next fetch is also at PC+1. The accumulator is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; two periods form one processor cycle |
| rst | input | 1 | Synchronous reset, active high |
| phi2 | input | 1 | Phase marker: 0 = first half, 1 = second half |
| dataIn | input | 8 | Read-data bus |
| addrBus | output | 16 | Address bus |
| rwRead | output | 1 | 1 = read cycle, 0 = write cycle |
| dataOut | output | 8 | Write-data bus |

## Verification
The bench checks the address and the strobe once in each half of every cycle. They are due in the clock period that starts the phi1 half, so each one is compared in both halves of its cycle. Write data is due one clock later, in the period where phi2 is high. Its check therefore expects the old byte in phi1 and the accumulator in phi2. Data read on the edge that ends phi2 cannot be seen at once. Its effect reaches the ports one or more cycles later, as the address of the next fetch or of the effective access, or as the byte driven by a later store, and the expected trace places it there. The bench drives random data into `dataIn` during every phi1 half, so any capture in the wrong phase shows up as a wrong stored byte.

// File: rtl/absbus_pkg.sv
package absbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] OP_LDA_IMM = 8'hA9;
  localparam logic [DATA_W-1:0] OP_LDA_ABS = 8'hAD;
  localparam logic [DATA_W-1:0] OP_STA_ABS = 8'h8D;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_IMM,
    ST_LO,
    ST_HI,
    ST_EFF,
    ST_IDLE
  } seqState_t;

  typedef struct packed {
    logic useEa;
    logic incPc;
    logic takeLo;
    logic takeHi;
    logic takeAcc;
    logic writeCyc;
  } ctrlStrobe_t;
endpackage

// File: rtl/absbus_ctrl.sv
module absbus_ctrl
  import absbus_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic [DW-1:0] dataIn,
  output ctrlStrobe_t   strobe
);
  seqState_t stateQ, stateD;
  logic storeQ, storeD;

  always_comb begin
    stateD = stateQ;
    storeD = storeQ;
    strobe = '0;
    unique case (stateQ)
      ST_OPC: begin
        strobe.incPc = 1'b1;
        storeD = (dataIn == OP_STA_ABS);
        if (dataIn == OP_LDA_ABS || dataIn == OP_STA_ABS) stateD = ST_LO;
        else if (dataIn == OP_LDA_IMM) stateD = ST_IMM;
        else stateD = ST_IDLE;
      end
      ST_IMM: begin
        strobe.incPc = 1'b1;
        strobe.takeAcc = 1'b1;
        stateD = ST_OPC;
      end
      ST_LO: begin
        strobe.incPc = 1'b1;
        strobe.takeLo = 1'b1;
        stateD = ST_HI;
      end
      ST_HI: begin
        strobe.incPc = 1'b1;
        strobe.takeHi = 1'b1;
        stateD = ST_EFF;
      end
      ST_EFF: begin
        strobe.useEa = 1'b1;
        strobe.takeAcc = !storeQ;
        strobe.writeCyc = storeQ;
        stateD = ST_OPC;
      end
      default: stateD = ST_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_OPC;
      storeQ <= 1'b0;
    end else if (phi2) begin
      stateQ <= stateD;
      storeQ <= storeD;
    end
  end

  AST_STATE_HOLD_PHI1: assert property (@(posedge clk) disable iff (rst)
    !phi2 |=> $stable(stateQ)) else $error("state moved in phi1"); // R8
endmodule

// File: rtl/absbus_dp.sv
module absbus_dp
  import absbus_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic [DW-1:0] dataIn,
  input  ctrlStrobe_t   strobe,
  output logic [AW-1:0] addrBus,
  output logic          rwRead,
  output logic [DW-1:0] dataOut
);
  localparam int HW = AW - DW;

  logic [AW-1:0] pcQ;
  logic [DW-1:0] accQ;
  logic [DW-1:0] eaLoQ;
  logic [HW-1:0] eaHiQ;
  logic [DW-1:0] doutQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= '0;
      accQ  <= '0;
      eaLoQ <= '0;
      eaHiQ <= '0;
      doutQ <= '0;
    end else if (phi2) begin
      if (strobe.incPc)   pcQ   <= pcQ + 1'b1;
      if (strobe.takeLo)  eaLoQ <= dataIn;
      if (strobe.takeHi)  eaHiQ <= HW'(dataIn);
      if (strobe.takeAcc) accQ  <= dataIn;
    end else if (strobe.writeCyc) begin
      doutQ <= accQ;
    end
  end

  assign addrBus = strobe.useEa ? {eaHiQ, eaLoQ} : pcQ;
  assign rwRead  = !strobe.writeCyc;
  assign dataOut = doutQ;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !phi2 |=> ($stable(addrBus) && $stable(rwRead))) else $error("bus moved mid-cycle"); // R8
  AST_DOUT_PHI2_ONLY: assert property (@(posedge clk) disable iff (rst)
    phi2 |=> $stable(dataOut)) else $error("write data moved outside phi2"); // R7
  AST_ACC_PHI1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phi2 |=> $stable(accQ)) else $error("accumulator loaded in phi1"); // R6
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pcQ == $past(pcQ) || pcQ == $past(pcQ) + 1'b1)) else $error("pc jumped"); // R4
endmodule

// File: rtl/absbus_seq.sv
module absbus_seq
  import absbus_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2,
  input  logic [DW-1:0] dataIn,
  output logic [AW-1:0] addrBus,
  output logic          rwRead,
  output logic [DW-1:0] dataOut
);
  ctrlStrobe_t strobe;

  absbus_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst(rst), .phi2(phi2), .dataIn(dataIn), .strobe(strobe)
  );

  absbus_dp #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rst(rst), .phi2(phi2), .dataIn(dataIn), .strobe(strobe),
    .addrBus(addrBus), .rwRead(rwRead), .dataOut(dataOut)
  );
endmodule

// File: tb/absbus_seq_tb_top.sv
module absbus_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2 = 1'b0;
  logic [7:0] dataIn;
  logic [15:0] addrBus;
  logic rwRead;
  logic [7:0] dataOut;

  logic [7:0] mem [256];
  logic [7:0] junk = 8'h00;
  int checks = 0;
  int errors = 0;

  logic [15:0] mPc;
  logic [7:0] mAcc;
  logic [7:0] mDout;

  always #5 clk = ~clk;

  always_comb dataIn = phi2 ? mem[addrBus[7:0]] : junk;

  absbus_seq dut_i (
    .clk(clk), .rst(rst), .phi2(phi2), .dataIn(dataIn),
    .addrBus(addrBus), .rwRead(rwRead), .dataOut(dataOut)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem[a[7:0]];
  endfunction

  // one processor cycle; entered just after a clock edge
  task automatic busCycle(input string req, input logic [15:0] expAddr, input logic expRw, input logic [7:0] expD2);
    phi2 = 1'b0;
    junk = 8'($urandom);
    @(negedge clk);
    chk(req, "addr phi1", addrBus, expAddr);
    chk("R5", "rw phi1", {15'd0, rwRead}, {15'd0, expRw});
    chk("R7", "dout phi1", {8'd0, dataOut}, {8'd0, mDout});
    @(posedge clk); #1;
    phi2 = 1'b1;
    @(negedge clk);
    chk("R8", "addr phi2", addrBus, expAddr);
    chk("R5", "rw phi2", {15'd0, rwRead}, {15'd0, expRw});
    chk("R7", "dout phi2", {8'd0, dataOut}, {8'd0, expD2});
    @(posedge clk); #1;
  endtask

  task automatic runInstr();
    logic [7:0] op;
    logic [15:0] ea;
    op = rd(mPc);
    busCycle("R4", mPc, 1'b1, mDout);
    if (op == 8'hA9) begin
      busCycle("R9", mPc + 16'd1, 1'b1, mDout);
      mAcc = rd(mPc + 16'd1);
      mPc = mPc + 16'd2;
    end else if (op == 8'hAD || op == 8'h8D) begin
      busCycle("R2", mPc + 16'd1, 1'b1, mDout);
      busCycle("R2", mPc + 16'd2, 1'b1, mDout);
      ea = {rd(mPc + 16'd2), rd(mPc + 16'd1)};
      mPc = mPc + 16'd3;
      if (op == 8'hAD) begin
        busCycle("R3", ea, 1'b1, mDout);
        mAcc = rd(ea);
      end else begin
        busCycle("R3", ea, 1'b0, mAcc);
        mDout = mAcc;
        mem[ea[7:0]] = mAcc;
      end
    end else begin
      busCycle("R10", mPc + 16'd1, 1'b1, mDout);
      mPc = mPc + 16'd1;
    end
  endtask

  int len = 0;
  task automatic put(input logic [7:0] b);
    mem[len] = b;
    len++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'hEA : 8'($urandom);
    // directed: immediate, store, load back, odd opcode, store again
    put(8'hA9); put(8'hAB);
    put(8'h8D); put(8'h9A); put(8'h12);
    put(8'hA9); put(8'h00);
    put(8'hAD); put(8'h9A); put(8'h12);
    put(8'h02);
    put(8'h8D); put(8'hC5); put(8'h77);
    while (len < 122) begin
      int kind;
      kind = int'($urandom_range(0, 3));
      if (kind == 0) begin put(8'hA9); put(8'($urandom)); end
      else if (kind == 1 || kind == 2) begin
        put(kind == 1 ? 8'hAD : 8'h8D); put(8'h80 | 8'($urandom_range(0, 127))); put(8'($urandom));
      end else begin
        logic [7:0] b;
        b = 8'($urandom);
        if (b == 8'hA9 || b == 8'hAD || b == 8'h8D) b = 8'hEA;
        put(b);
      end
    end

    rst = 1'b1;
    phi2 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "addr in reset", addrBus, 16'h0000);
    chk("R1", "rw in reset", {15'd0, rwRead}, 16'd1);
    chk("R1", "dout in reset", {8'd0, dataOut}, 16'd0);
    rst = 1'b0;
    mPc = 16'h0000; mAcc = 8'h00; mDout = 8'h00;
    while (mPc < 16'(len)) runInstr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule